// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a two-field logical address into a physical address. The upper field picks a segment, the lower field is an offset inside that segment. A small table inside the block holds, for every segment, a starting physical address, a length and a present flag. A lookup reads the entry that the segment field selects and compares the offset with the length. If the offset fits, the result is the segment start plus the offset. If it does not fit, the lookup reports an addressing trap and no access goes out.

The table is loaded through a configuration port. That port only takes effect while the kernel-mode input is high, so user code cannot move its own window. Each lookup produces a registered response one clock after the request. Segment count and field widths are parameters. The limit field is one bit wider than the offset so that a segment can span the full offset range.

Top module: `seg_xlate`

## Requirements
- R1: Reset clears every entry's present flag and holds `rsp_valid` low; after reset every lookup reports trap code 2.
- R2: A request sampled on a clock edge gives `rsp_valid` high after that same edge, for exactly one cycle per request; with no request `rsp_valid` is low.
- R3: When the entry is present and the offset is strictly below its limit, the response carries trap code 0, `rsp_ok` high and `rsp_paddr` equal to base plus offset.
- R4: When the entry is present and the offset is equal to or above its limit, the response carries trap code 1, `rsp_ok` low and `rsp_paddr` zero.
- R5: A lookup of an entry whose present flag is clear carries trap code 2, `rsp_ok` low and `rsp_paddr` zero, whatever the offset.
- R6: A segment number of `NUM_SEGS` or above carries trap code 2 with `rsp_ok` low.
- R7: A table write changes the entry only when `cfg_we` and `cfg_kernel` are both high on the clock edge; with `cfg_kernel` low the entry keeps its contents.
- R8: A lookup in the same cycle as a write to the same entry uses the contents from before the write; the next lookup sees the new contents.
- R9: The physical address is the sum of base and offset taken modulo 2^`PA_W`.
- R10: A present entry with limit 0 traps every offset with code 1; the absent check takes priority over the limit check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_kernel | input | 1 | Kernel mode; writes are honoured only when high |
| cfg_idx | input | SEG_W | Entry to write |
| cfg_base | input | PA_W | Segment start address to store |
| cfg_limit | input | OFS_W+1 | Segment length to store |
| cfg_present | input | 1 | Present flag to store |
| req_valid | input | 1 | Lookup request |
| req_seg | input | SEG_W | Segment number of the logical address |
| req_ofs | input | OFS_W | Offset of the logical address |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_ok | output | 1 | Translation legal; a memory access may be issued |
| rsp_trap | output | 2 | Trap code: 0 none, 1 out of bounds, 2 segment absent |
| rsp_paddr | output | PA_W | Physical address, zero on a trap |

## Verification
A corrupted base shows as a wrong `rsp_paddr` on the first legal lookup of that segment, one cycle after the request. A corrupted limit only shows when an offset falls between the true and the stored limit, so the bench probes offsets at limit-1, limit and far above. A lost present flag or a write that slips past the kernel gate shows as a wrong trap code on the next lookup of that entry. A stale or early table update shows only when a lookup and a write meet in the same cycle.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    TRAP_NONE   = 2'd0,
    TRAP_BOUND  = 2'd1,
    TRAP_ABSENT = 2'd2
  } trap_e;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W    = 3,
  parameter int NUM_SEGS = 6,
  parameter int PA_W     = 16,
  parameter int LIM_W    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [LIM_W-1:0] wr_limit,
  input  logic             wr_present,
  input  logic [SEG_W-1:0] rd_idx,
  output logic [PA_W-1:0]  rd_base,
  output logic [LIM_W-1:0] rd_limit,
  output logic             rd_present
);
  logic [PA_W-1:0]  base_q  [NUM_SEGS];
  logic [LIM_W-1:0] limit_q [NUM_SEGS];
  logic             pres_q  [NUM_SEGS];

  for (genvar i = 0; i < NUM_SEGS; i++) begin : g_entry
    logic hit_wr;
    assign hit_wr = wr_en && (wr_idx == SEG_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
        pres_q[i]  <= 1'b0;
      end else if (hit_wr) begin
        base_q[i]  <= wr_base;
        limit_q[i] <= wr_limit;
        pres_q[i]  <= wr_present;
      end
    end
  end

  // Indices at or above NUM_SEGS select nothing and read as absent.
  always_comb begin
    rd_base    = '0;
    rd_limit   = '0;
    rd_present = 1'b0;
    for (int i = 0; i < NUM_SEGS; i++) begin
      if (rd_idx == SEG_W'(i)) begin
        rd_base    = base_q[i];
        rd_limit   = limit_q[i];
        rd_present = pres_q[i];
      end
    end
  end
endmodule

// File: rtl/seg_check.sv
module seg_check #(
  parameter int OFS_W = 12,
  parameter int PA_W  = 16,
  parameter int LIM_W = 13
) (
  input  logic             present,
  input  logic [PA_W-1:0]  base,
  input  logic [LIM_W-1:0] limit,
  input  logic [OFS_W-1:0] ofs,
  output seg_pkg::trap_e   trap,
  output logic [PA_W-1:0]  paddr
);
  import seg_pkg::*;
  localparam int SUM_W = (PA_W > OFS_W) ? PA_W : OFS_W;

  logic             in_bounds;
  logic [SUM_W-1:0] sum;

  assign in_bounds = LIM_W'(ofs) < limit;
  assign sum       = SUM_W'(base) + SUM_W'(ofs);

  always_comb begin
    if (!present) begin
      trap  = TRAP_ABSENT;
      paddr = '0;
    end else if (!in_bounds) begin
      trap  = TRAP_BOUND;
      paddr = '0;
    end else begin
      trap  = TRAP_NONE;
      paddr = sum[PA_W-1:0];
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W    = 3,
  parameter int NUM_SEGS = 6,
  parameter int OFS_W    = 12,
  parameter int PA_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_kernel,
  input  logic [SEG_W-1:0] cfg_idx,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [OFS_W:0]   cfg_limit,
  input  logic             cfg_present,
  input  logic             req_valid,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFS_W-1:0] req_ofs,
  output logic             rsp_valid,
  output logic             rsp_ok,
  output logic [1:0]       rsp_trap,
  output logic [PA_W-1:0]  rsp_paddr
);
  import seg_pkg::*;
  localparam int LIM_W = OFS_W + 1;

  logic             tbl_we;
  logic [PA_W-1:0]  ent_base;
  logic [LIM_W-1:0] ent_limit;
  logic             ent_present;
  trap_e            chk_trap;
  logic [PA_W-1:0]  chk_paddr;

  logic             valid_d, valid_q;
  logic             ok_d, ok_q;
  trap_e            trap_d, trap_q;
  logic [PA_W-1:0]  paddr_d, paddr_q;

  assign tbl_we = cfg_we && cfg_kernel;

  seg_table #(.SEG_W(SEG_W), .NUM_SEGS(NUM_SEGS), .PA_W(PA_W), .LIM_W(LIM_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (tbl_we),
    .wr_idx     (cfg_idx),
    .wr_base    (cfg_base),
    .wr_limit   (cfg_limit),
    .wr_present (cfg_present),
    .rd_idx     (req_seg),
    .rd_base    (ent_base),
    .rd_limit   (ent_limit),
    .rd_present (ent_present)
  );

  seg_check #(.OFS_W(OFS_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_check (
    .present (ent_present),
    .base    (ent_base),
    .limit   (ent_limit),
    .ofs     (req_ofs),
    .trap    (chk_trap),
    .paddr   (chk_paddr)
  );

  always_comb begin
    valid_d = req_valid;
    if (req_valid) begin
      trap_d  = chk_trap;
      paddr_d = chk_paddr;
      ok_d    = (chk_trap == TRAP_NONE);
    end else begin
      trap_d  = TRAP_NONE;
      paddr_d = '0;
      ok_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ok_q    <= 1'b0;
      trap_q  <= TRAP_NONE;
      paddr_q <= '0;
    end else begin
      valid_q <= valid_d;
      ok_q    <= ok_d;
      trap_q  <= trap_d;
      paddr_q <= paddr_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_ok    = ok_q;
  assign rsp_trap  = trap_q;
  assign rsp_paddr = paddr_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W    = 3,
  parameter int NUM_SEGS = 6,
  parameter int PA_W     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [SEG_W-1:0] req_seg,
  input logic             rsp_valid,
  input logic             rsp_ok,
  input logic [1:0]       rsp_trap,
  input logic [PA_W-1:0]  rsp_paddr
);
  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_high_seg_absent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (32'(req_seg) >= NUM_SEGS)) |=> (rsp_trap == 2'd2 && !rsp_ok));

  p_trap_blocks_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_trap != 2'd0) |-> (!rsp_ok && rsp_paddr == '0));

  p_known_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_trap != 2'd3));
endmodule

bind seg_xlate seg_xlate_chk #(.SEG_W(SEG_W), .NUM_SEGS(NUM_SEGS), .PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_seg   (req_seg),
  .rsp_valid (rsp_valid),
  .rsp_ok    (rsp_ok),
  .rsp_trap  (rsp_trap),
  .rsp_paddr (rsp_paddr)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  localparam int SEG_W = 3, NSEG = 6, OFS_W = 12, PA_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_kernel = 0, cfg_present = 0;
  logic [SEG_W-1:0] cfg_idx = '0, req_seg = '0;
  logic [PA_W-1:0]  cfg_base = '0;
  logic [OFS_W:0]   cfg_limit = '0;
  logic req_valid = 0;
  logic [OFS_W-1:0] req_ofs = '0;
  logic rsp_valid, rsp_ok;
  logic [1:0] rsp_trap;
  logic [PA_W-1:0] rsp_paddr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [PA_W-1:0] m_base [8];
  logic [OFS_W:0]  m_lim  [8];
  logic            m_pres [8];

  logic [1:0]      q_trap [$];
  logic [PA_W-1:0] q_pa   [$];
  string           q_tag  [$];

  always #5 clk = ~clk;

  seg_xlate #(.SEG_W(SEG_W), .NUM_SEGS(NSEG), .OFS_W(OFS_W), .PA_W(PA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kernel(cfg_kernel),
    .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .cfg_present(cfg_present), .req_valid(req_valid), .req_seg(req_seg),
    .req_ofs(req_ofs), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_trap(rsp_trap), .rsp_paddr(rsp_paddr));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected response from the model as it stands before this cycle's write.
  task automatic push_exp(logic [SEG_W-1:0] s, logic [OFS_W-1:0] o, string tag);
    logic [PA_W:0] sum;
    if (32'(s) >= NSEG || !m_pres[s]) begin
      q_trap.push_back(2'd2); q_pa.push_back('0);
    end else if ({1'b0, o} >= m_lim[s]) begin
      q_trap.push_back(2'd1); q_pa.push_back('0);
    end else begin
      sum = {1'b0, m_base[s]} + (PA_W+1)'(o);
      q_trap.push_back(2'd0); q_pa.push_back(sum[PA_W-1:0]);
    end
    q_tag.push_back(tag);
  endtask

  // One cycle carrying an optional write and an optional lookup.
  task automatic cyc(bit we, bit kern, logic [SEG_W-1:0] wi, logic [PA_W-1:0] wb,
                     logic [OFS_W:0] wl, bit wp,
                     bit rv, logic [SEG_W-1:0] s, logic [OFS_W-1:0] o, string tag);
    cfg_we = we; cfg_kernel = kern; cfg_idx = wi; cfg_base = wb;
    cfg_limit = wl; cfg_present = wp;
    req_valid = rv; req_seg = s; req_ofs = o;
    if (rv) push_exp(s, o, tag);
    @(negedge clk);
    if (we && kern && 32'(wi) < NSEG) begin
      m_base[wi] = wb; m_lim[wi] = wl; m_pres[wi] = wp;
    end
    cfg_we = 0; req_valid = 0;
  endtask

  task automatic wr(bit kern, logic [SEG_W-1:0] wi, logic [PA_W-1:0] wb,
                    logic [OFS_W:0] wl, bit wp);
    cyc(1, kern, wi, wb, wl, wp, 0, '0, '0, "");
  endtask

  task automatic lk(logic [SEG_W-1:0] s, logic [OFS_W-1:0] o, string tag);
    cyc(0, 0, '0, '0, '0, 0, 1, s, o, tag);
  endtask

  // Monitor: pops one expected item per response.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (q_tag.size() == 0) begin
          check("R2 unexpected response", 32'(rsp_valid), 32'd0);
        end else begin
          string t;
          logic [1:0] et;
          logic [PA_W-1:0] ep;
          t = q_tag.pop_front(); et = q_trap.pop_front(); ep = q_pa.pop_front();
          check({t, " trap"}, 32'(rsp_trap), 32'(et));
          check({t, " paddr"}, 32'(rsp_paddr), 32'(ep));
          check({t, " ok"}, 32'(rsp_ok), 32'(et == 2'd0));
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_base[i] = '0; m_lim[i] = '0; m_pres[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R1 paddr after reset", 32'(rsp_paddr), 32'd0);
    for (int s = 0; s < 8; s++) lk(SEG_W'(s), 12'd0, "R1 absent after reset");

    wr(1, 3'd2, 16'd4300, 13'd2000, 1);
    wr(1, 3'd0, 16'd100, 13'd1000, 1);
    wr(1, 3'd1, 16'd65000, 13'd4096, 1);
    wr(1, 3'd3, 16'd777, 13'd0, 1);
    lk(3'd2, 12'd53, "R3 seg2+53");
    lk(3'd0, 12'd999, "R3 limit-1");
    lk(3'd0, 12'd1000, "R4 offset equals limit");
    lk(3'd0, 12'd1222, "R4 offset over limit");
    lk(3'd1, 12'd4095, "R9 wrap");
    lk(3'd3, 12'd0, "R10 zero limit");
    lk(3'd4, 12'd5, "R5 never written");
    lk(3'd6, 12'd0, "R6 seg 6");
    lk(3'd7, 12'd0, "R6 seg 7");

    wr(0, 3'd5, 16'd500, 13'd10, 1);
    lk(3'd5, 12'd9, "R7 user write ignored");
    wr(1, 3'd5, 16'd500, 13'd10, 1);
    lk(3'd5, 12'd9, "R7 kernel write");
    wr(0, 3'd5, 16'd900, 13'd10, 1);
    lk(3'd5, 12'd9, "R7 user overwrite ignored");

    cyc(1, 1, 3'd5, 16'd800, 13'd20, 1, 1, 3'd5, 12'd15, "R8 same cycle old");
    lk(3'd5, 12'd15, "R8 next cycle new");

    wr(1, 3'd2, 16'd4300, 13'd2000, 0);
    lk(3'd2, 12'd53, "R5 present cleared");
    wr(1, 3'd2, 16'd4300, 13'd0, 0);
    lk(3'd2, 12'd4000, "R10 absent over bound");

    // Back-to-back lookups, then idle gap.
    lk(3'd0, 12'd0, "R2 burst a");
    lk(3'd1, 12'd1, "R2 burst b");
    lk(3'd0, 12'd5, "R2 burst c");
    repeat (3) @(negedge clk);
    check("R2 idle rsp_valid", 32'(rsp_valid), 32'd0);
    check("R2 queue drained", 32'(q_tag.size()), 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule